// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block turns the immediate-offset addressing forms of a 64-bit load/store instruction set into an effective memory address and a base-register writeback. Each accepted request carries an addressing mode, a base register index, the base register value, the stack pointer value, an access size and the raw immediate field. One cycle later the block presents the address, the writeback enable and value, a stack-pointer alignment fault flag, and the load result. The load result is the supplied memory data, zero-extended when the access is 32 bits.

Two immediate readings are supported. The first is a signed byte offset with no scaling. The second is an unsigned offset scaled by the access size. The pre-index and post-index forms use the signed byte offset and write the sum back to the base register. Register index 31 names the stack pointer, and selecting it triggers an alignment check.

The control is a two-state machine. `ST_IDLE` means no result is being presented. `ST_EMIT` presents a result for one cycle. There are two transitions. A strobe in either state leads to `ST_EMIT` (the "accept" transition). No strobe leads to `ST_IDLE` (the "drain" transition).

Top module: `lsag_top`

## Requirements
- R1: Mode 2'b00 (unscaled): address = base + sign-extended `imm_field[8:0]`, writeback enable 0, writeback value = base.
- R2: Mode 2'b01 (scaled): address = base + `imm_field[11:0]` shifted left by 2 when `size64`=0 and by 3 when `size64`=1 (byte offset 0..16380 or 0..32760), writeback enable 0.
- R3: Mode 2'b10 (pre-index): address = base + sign-extended `imm_field[8:0]`, writeback enable 1, writeback value equals the address.
- R4: Mode 2'b11 (post-index): address = unmodified base, writeback enable 1, writeback value = base + sign-extended `imm_field[8:0]`.
- R5: When `base_idx` is 31, `sp_val` is used as the base instead of `base_val`.
- R6: When `base_idx` is 31 and `sp_val[3:0]` is nonzero, `sp_fault` is 1 and the writeback enable is forced to 0. Otherwise `sp_fault` is 0.
- R7: An address that is not aligned to the access size, such as a 32-bit access at 0x52 through a general register, raises no fault.
- R8: `load_data` = {32'b0, `mem_rdata[31:0]`} when `size64`=0. It is `mem_rdata` unchanged when `size64`=1.
- R9: Address and writeback arithmetic is modulo 2^64 and wraps silently in both directions.
- R10: All results appear with `out_valid`=1 exactly one cycle after `in_valid`. Back-to-back strobes give back-to-back results. After reset, `out_valid`, `wb_en` and `sp_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | 00 unscaled, 01 scaled, 10 pre-index, 11 post-index |
| base_idx | input | 5 | Base register index (31 = stack pointer) |
| base_val | input | 64 | General base register value |
| sp_val | input | 64 | Stack pointer value |
| size64 | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| imm_field | input | 12 | Raw immediate field |
| mem_rdata | input | 64 | Memory read data for the load result |
| out_valid | output | 1 | Result valid |
| addr | output | 64 | Effective address |
| wb_en | output | 1 | Base writeback enable |
| wb_val | output | 64 | Base writeback value |
| sp_fault | output | 1 | Stack pointer misalignment fault |
| load_data | output | 64 | Zero-extended load result |

## Verification
The assertions assume two things about the inputs. A mode, index and value presented with `in_valid` are meaningful only in that cycle. The stack pointer alignment depends only on `sp_val`, never on the offset. The stimulus drives every field on the falling edge, together with the strobe. It reaches fault conditions only through index 31 with a misaligned `sp_val`, and it places misaligned bases on general registers to show that they pass through unflagged. Offsets span the extremes of both immediate fields, and the bases are chosen so that sums wrap past zero and past the top of the address space.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
    typedef enum logic [1:0] {
        AM_UNSCALED = 2'b00,
        AM_SCALED   = 2'b01,
        AM_PRE      = 2'b10,
        AM_POST     = 2'b11
    } addr_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } lsag_state_e;
endpackage

// File: rtl/lsag_imm_decode.sv
module lsag_imm_decode #(
    parameter int ADDR_W = 64,
    parameter int SIMM_W = 9,
    parameter int UIMM_W = 12
) (
    input  logic [UIMM_W-1:0] imm_field,
    input  logic              size64,
    output logic [ADDR_W-1:0] off_signed,
    output logic [ADDR_W-1:0] off_scaled
);
    localparam int SEXT_W = ADDR_W - SIMM_W;
    localparam int ZEXT_W = ADDR_W - UIMM_W;

    logic [ADDR_W-1:0] uimm_wide;

    always_comb begin
        off_signed = {{SEXT_W{imm_field[SIMM_W-1]}}, imm_field[SIMM_W-1:0]};
        uimm_wide  = {{ZEXT_W{1'b0}}, imm_field};
        off_scaled = size64 ? (uimm_wide << 3) : (uimm_wide << 2);
    end
endmodule

// File: rtl/lsag_addr_unit.sv
module lsag_addr_unit
    import lsag_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 5
) (
    input  addr_mode_e        mode,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] sp_val,
    input  logic [ADDR_W-1:0] off_signed,
    input  logic [ADDR_W-1:0] off_scaled,
    output logic [ADDR_W-1:0] ea,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_sum
);
    localparam logic [IDX_W-1:0] SP_IDX = '1;

    logic [ADDR_W-1:0] base_eff;
    logic [ADDR_W-1:0] sum_signed;

    always_comb begin
        base_eff   = (base_idx == SP_IDX) ? sp_val : base_val;
        sum_signed = base_eff + off_signed;
        ea         = base_eff;
        wb_req     = 1'b0;
        wb_sum     = base_eff;
        unique case (mode)
            AM_UNSCALED: ea = sum_signed;
            AM_SCALED:   ea = base_eff + off_scaled;
            AM_PRE: begin
                ea     = sum_signed;
                wb_req = 1'b1;
                wb_sum = sum_signed;
            end
            AM_POST: begin
                ea     = base_eff;
                wb_req = 1'b1;
                wb_sum = sum_signed;
            end
            default: ea = base_eff;
        endcase
    end

    always_comb begin
        if (mode == AM_POST)
            a_r4_post_uses_base: assert (ea == base_eff);
    end
endmodule

// File: rtl/lsag_sp_check.sv
module lsag_sp_check #(
    parameter int ADDR_W     = 64,
    parameter int IDX_W      = 5,
    parameter int ALIGN_BITS = 4
) (
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [ADDR_W-1:0] sp_val,
    output logic              fault
);
    localparam logic [IDX_W-1:0] SP_IDX = '1;

    always_comb begin
        fault = (base_idx == SP_IDX) && (|sp_val[ALIGN_BITS-1:0]);
    end
endmodule

// File: rtl/lsag_top.sv
module lsag_top
    import lsag_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int IDX_W      = 5,
    parameter int SIMM_W     = 9,
    parameter int UIMM_W     = 12,
    parameter int ALIGN_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        mode,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] sp_val,
    input  logic              size64,
    input  logic [UIMM_W-1:0] imm_field,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              out_valid,
    output logic [ADDR_W-1:0] addr,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_val,
    output logic              sp_fault,
    output logic [ADDR_W-1:0] load_data
);
    localparam int HALF_W = ADDR_W / 2;
    localparam logic [IDX_W-1:0] SP_IDX = '1;

    lsag_state_e       state_q, state_d;
    addr_mode_e        mode_e;
    logic [ADDR_W-1:0] off_signed, off_scaled, ea, wb_sum, ld_ext;
    logic              wb_req, fault;

    assign mode_e = addr_mode_e'(mode);

    lsag_imm_decode #(.ADDR_W(ADDR_W), .SIMM_W(SIMM_W), .UIMM_W(UIMM_W)) u_imm (
        .imm_field (imm_field),
        .size64    (size64),
        .off_signed(off_signed),
        .off_scaled(off_scaled)
    );

    lsag_addr_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
        .mode      (mode_e),
        .base_idx  (base_idx),
        .base_val  (base_val),
        .sp_val    (sp_val),
        .off_signed(off_signed),
        .off_scaled(off_scaled),
        .ea        (ea),
        .wb_req    (wb_req),
        .wb_sum    (wb_sum)
    );

    lsag_sp_check #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_BITS(ALIGN_BITS)) u_sp (
        .base_idx(base_idx),
        .sp_val  (sp_val),
        .fault   (fault)
    );

    always_comb begin
        ld_ext = size64 ? mem_rdata : {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign out_valid = (state_q == ST_EMIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr      <= '0;
            wb_en     <= 1'b0;
            wb_val    <= '0;
            sp_fault  <= 1'b0;
            load_data <= '0;
        end else if (in_valid) begin
            addr      <= ea;
            wb_en     <= wb_req && !fault;
            wb_val    <= wb_sum;
            sp_fault  <= fault;
            load_data <= ld_ext;
        end else begin
            wb_en    <= 1'b0;
            sp_fault <= 1'b0;
        end
    end

    a_r10_result_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r6_fault_blocks_wb: assert property (@(posedge clk) disable iff (!rst_n)
        sp_fault |-> !wb_en);
    a_r6_fault_only_on_sp: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (base_idx != SP_IDX) |=> !sp_fault);
    a_r3_pre_wb_equals_addr: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (mode == 2'b10) |=> wb_val == addr);
    a_r1_offset_forms_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !mode[1] |=> !wb_en);
    a_r8_upper_zero_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !size64 |=> load_data[ADDR_W-1:HALF_W] == '0);
endmodule

// File: tb/lsag_top_bench.sv
module lsag_top_bench;
    typedef struct {
        logic [63:0] addr;
        logic        wb_en;
        logic [63:0] wb_val;
        logic        fault;
        logic [63:0] ld;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = '0;
    logic [4:0]  base_idx = '0;
    logic [63:0] base_val = '0, sp_val = '0, mem_rdata = '0;
    logic        size64 = 1'b0;
    logic [11:0] imm_field = '0;
    logic        out_valid, wb_en, sp_fault;
    logic [63:0] addr, wb_val, load_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    exp_t sb[$];

    always #4 clk = ~clk;

    lsag_top u_lsag_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .base_idx(base_idx), .base_val(base_val), .sp_val(sp_val),
        .size64(size64), .imm_field(imm_field), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .addr(addr), .wb_en(wb_en), .wb_val(wb_val),
        .sp_fault(sp_fault), .load_data(load_data)
    );

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic [1:0] m, input logic [4:0] idx,
                         input logic [63:0] b, input logic [63:0] sp, input logic s64,
                         input logic [11:0] imm, input logic [63:0] rd);
        exp_t e;
        logic [63:0] base, soff, uoff, ssum;
        base = (idx == 5'd31) ? sp : b;
        soff = {{55{imm[8]}}, imm[8:0]};
        uoff = {52'd0, imm} * (s64 ? 64'd8 : 64'd4);
        ssum = base + soff;
        e.fault = (idx == 5'd31) && (sp[3:0] != 4'd0);
        e.ld = s64 ? rd : {32'd0, rd[31:0]};
        e.tag = tag;
        case (m)
            2'b00: begin e.addr = ssum; e.wb_en = 0; e.wb_val = base; end
            2'b01: begin e.addr = base + uoff; e.wb_en = 0; e.wb_val = base; end
            2'b10: begin e.addr = ssum; e.wb_en = !e.fault; e.wb_val = ssum; end
            default: begin e.addr = base; e.wb_en = !e.fault; e.wb_val = ssum; end
        endcase
        @(negedge clk);
        in_valid = 1; mode = m; base_idx = idx; base_val = b; sp_val = sp;
        size64 = s64; imm_field = imm; mem_rdata = rd;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 unexpected out_valid act=1 exp=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check64({e.tag, " addr"}, addr, e.addr);
                check64({e.tag, " wb_en"}, {63'd0, wb_en}, {63'd0, e.wb_en});
                check64({e.tag, " wb_val"}, wb_val, e.wb_val);
                check64({e.tag, " sp_fault"}, {63'd0, sp_fault}, {63'd0, e.fault});
                check64({e.tag, " load_data"}, load_data, e.ld);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog act=hung exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check64("R10 reset out_valid", {63'd0, out_valid}, 64'd0);
        check64("R10 reset wb_en", {63'd0, wb_en}, 64'd0);
        check64("R10 reset sp_fault", {63'd0, sp_fault}, 64'd0);
        rst_n = 1;
        // R1 unscaled +8, -256, +255
        drive("R1 plus8", 2'b00, 5'd1, 64'h50, 64'h0, 1, 12'd8, 64'hDEAD_BEEF_0123_4567);
        drive("R1 minus256", 2'b00, 5'd2, 64'h1000, 64'h0, 1, 12'h100, 64'h1);
        drive("R1 plus255", 2'b00, 5'd3, 64'h1000, 64'h0, 0, 12'h0FF, 64'h2);
        idle(2);
        check64("R10 idle no out_valid", {63'd0, out_valid}, 64'd0);
        // R2 scaled extremes
        drive("R2 scaled32 max", 2'b01, 5'd4, 64'h0, 64'h0, 0, 12'hFFF, 64'h3);
        drive("R2 scaled64 max", 2'b01, 5'd4, 64'h0, 64'h0, 1, 12'hFFF, 64'h4);
        drive("R2 scaled64 one", 2'b01, 5'd5, 64'h100, 64'h0, 1, 12'h001, 64'h5);
        // R3/R4
        drive("R3 pre neg", 2'b10, 5'd6, 64'h2000, 64'h0, 1, 12'h1F0, 64'h6);
        drive("R4 post pos", 2'b11, 5'd7, 64'h2000, 64'h0, 1, 12'h010, 64'h7);
        idle(1);
        // R5 sp alias, R6 faults
        drive("R5 sp aligned pre", 2'b10, 5'd31, 64'hAAAA, 64'h8000, 1, 12'h020, 64'h8);
        drive("R6 sp misaligned pre", 2'b10, 5'd31, 64'h0, 64'h8004, 1, 12'h010, 64'h9);
        drive("R6 sp misaligned post", 2'b11, 5'd31, 64'h0, 64'h8008, 0, 12'h008, 64'hA);
        drive("R6 gpr misaligned no fault", 2'b11, 5'd30, 64'h8003, 64'h8003, 1, 12'h001, 64'hB);
        // R7 misaligned unscaled 32-bit at 0x52
        drive("R7 misaligned", 2'b00, 5'd9, 64'h50, 64'h0, 0, 12'h002, 64'hC);
        // R8 zero-extend
        drive("R8 ld32", 2'b00, 5'd1, 64'h0, 64'h0, 0, 12'h0, 64'hFFFF_FFFF_8765_4321);
        drive("R8 ld64", 2'b00, 5'd1, 64'h0, 64'h0, 1, 12'h0, 64'hFFFF_FFFF_8765_4321);
        // R9 wrap
        drive("R9 wrap up", 2'b10, 5'd1, 64'hFFFF_FFFF_FFFF_FFF8, 64'h0, 1, 12'h010, 64'h0);
        drive("R9 wrap down", 2'b00, 5'd1, 64'h0, 64'h0, 1, 12'h1FF, 64'h0);
        drive("R9 scaled wrap", 2'b01, 5'd1, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0, 0, 12'h002, 64'h0);
        idle(3);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R10 pending results act=%0d exp=0", sb.size());
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule